// File: doc/BRIEF.md
# Paging Control Register Unit

This block keeps the three paging control registers of a 32-bit x86-style core (CR0, CR3 and CR4) together with the gate on physical address bit 20. Software-visible writes arrive over a single-cycle write port. A level input selects whether address bit 20 passes through. The block registers each new value. It then tells the translation cache to flush when a write changes a bit that alters address translation.

Every flush request is a one-cycle pulse. A companion bit tells the cache whether to drop every entry (full) or to keep global entries (non-global). A change of the bit-20 gate also pulses an exit request so that the execution unit abandons code it has already translated.

The block also presents a 32-bit address mask to the page walker. It derives the hidden mode flags that the decoder consults (protected mode, segment-base addition, and the three floating-point trap controls) from CR0. The stored register values are visible on output ports. All outputs are registered and change on the clock edge that follows the write strobe.

Top module: `paging_ctl_unit`

## Requirements
- R1: After reset, CR0 reads 0x60000010, CR3 and CR4 read 0, the address mask is 0xFFFFFFFF, and flush_req and exit_req are 0.
- R2: A write with wr_sel=0 stores wr_data into CR0 with bit 4 forced to 1, visible on cr0_q after the next clock edge.
- R3: A CR0 write requests a full flush (flush_req=1, flush_all=1) exactly when bit 31, bit 16 or bit 0 of the written value differs from the stored CR0.
- R4: A write with wr_sel=1 always stores wr_data into CR3. It requests a flush exactly when stored CR0 bit 31 is 1, and that flush is non-global (flush_all=0) unless another full-flush source is active in the same cycle.
- R5: A write with wr_sel=2 stores wr_data into CR4 and requests a full flush exactly when bit 7, bit 5 or bit 4 changes.
- R6: The address mask equals 0xFFEFFFFF with bit 20 set to the registered state of gate_en.
- R7: When gate_en differs from the registered gate state, the state updates and both a full flush and exit_req pulse. When gate_en equals the stored state, nothing happens.
- R8: The hidden flags follow CR0: hf_pe equals bit 0, hf_addseg is the inverse of bit 0, and hf_mp, hf_em and hf_ts equal bits 1, 2 and 3.
- R9: flush_req and exit_req are single-cycle pulses. When several flush sources coincide, one request is issued, and it is full if any source is full.
- R10: A write with wr_sel=3 changes no register and requests no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target: 0 CR0, 1 CR3, 2 CR4, 3 none |
| wr_data | input | 32 | Write value |
| gate_en | input | 1 | Address bit 20 enable level |
| cr0_q | output | 32 | Stored CR0 |
| cr3_q | output | 32 | Stored CR3 |
| cr4_q | output | 32 | Stored CR4 |
| addr_mask | output | 32 | Physical address mask for the page walker |
| flush_req | output | 1 | Translation cache flush pulse |
| flush_all | output | 1 | 1 full flush, 0 non-global flush (valid with flush_req) |
| exit_req | output | 1 | Exit pulse to the execution unit |
| hf_pe | output | 1 | Protected-mode hidden flag |
| hf_addseg | output | 1 | Segment-base addition hidden flag |
| hf_mp | output | 1 | Monitor-coprocessor hidden flag |
| hf_em | output | 1 | Emulation hidden flag |
| hf_ts | output | 1 | Task-switched hidden flag |

## Verification
The bench targets CR0 writes that rewrite the same paging bits while changing other bits. A design that compared the whole word would issue spurious flushes on those writes. It also targets CR3 writes with paging on and off, where a design that ignored CR0 bit 31 or chose the wrong flush kind would corrupt or over-flush the cache. It repeats the same gate level and drives a gate change together with a CR3 write, which exposes a design that flushes on a steady gate or lets the non-global kind win. Writes that clear bit 4, and writes to the unused select, catch a design that stores the raw value or decodes the select loosely.

// File: rtl/pgctl_pkg.sv
package pgctl_pkg;
  localparam int XLEN = 32;

  typedef enum logic [1:0] {
    SEL_CR0  = 2'd0,
    SEL_CR3  = 2'd1,
    SEL_CR4  = 2'd2,
    SEL_NONE = 2'd3
  } cr_sel_e;

  // CR0 bit positions
  localparam int B_PE = 0;
  localparam int B_MP = 1;
  localparam int B_EM = 2;
  localparam int B_TS = 3;
  localparam int B_ET = 4;
  localparam int B_WP = 16;
  localparam int B_PG = 31;
  // CR4 bit positions
  localparam int B_PSE = 4;
  localparam int B_PAE = 5;
  localparam int B_PGE = 7;
  // gated address bit
  localparam int B_GATE = 20;

  localparam logic [XLEN-1:0] CR0_RESET = 32'h6000_0010;

  function automatic logic [XLEN-1:0] cr0_store_val(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    r = v;
    r[B_ET] = 1'b1;
    return r;
  endfunction

  function automatic logic cr0_needs_flush(input logic [XLEN-1:0] cur,
                                           input logic [XLEN-1:0] nxt);
    return (cur[B_PG] ^ nxt[B_PG]) | (cur[B_WP] ^ nxt[B_WP]) | (cur[B_PE] ^ nxt[B_PE]);
  endfunction

  function automatic logic cr4_needs_flush(input logic [XLEN-1:0] cur,
                                           input logic [XLEN-1:0] nxt);
    return (cur[B_PGE] ^ nxt[B_PGE]) | (cur[B_PAE] ^ nxt[B_PAE]) | (cur[B_PSE] ^ nxt[B_PSE]);
  endfunction

  function automatic logic [XLEN-1:0] gate_mask(input logic en);
    logic [XLEN-1:0] m;
    m = '1;
    m[B_GATE] = en;
    return m;
  endfunction
endpackage

// File: rtl/pg_cr0_reg.sv
module pg_cr0_reg
  import pgctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] cr0_q,
  output logic            full_evt,
  output logic            hf_pe,
  output logic            hf_addseg,
  output logic            hf_mp,
  output logic            hf_em,
  output logic            hf_ts
);
  assign full_evt = wr && cr0_needs_flush(cr0_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n) cr0_q <= CR0_RESET;
    else if (wr) cr0_q <= cr0_store_val(data);
  end

  // hidden flags are kept in their own flops, loaded from the write data
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hf_pe     <= CR0_RESET[B_PE];
      hf_addseg <= ~CR0_RESET[B_PE];
      hf_mp     <= CR0_RESET[B_MP];
      hf_em     <= CR0_RESET[B_EM];
      hf_ts     <= CR0_RESET[B_TS];
    end else if (wr) begin
      hf_pe     <= data[B_PE];
      hf_addseg <= ~data[B_PE];
      hf_mp     <= data[B_MP];
      hf_em     <= data[B_EM];
      hf_ts     <= data[B_TS];
    end
  end

  AST_CR0_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cr0_q[B_ET] && cr0_q[XLEN-1:B_ET+1] == $past(data[XLEN-1:B_ET+1]))); // R2
  AST_HF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (hf_pe == cr0_q[B_PE]) && (hf_addseg != cr0_q[B_PE]) &&
    ({hf_ts, hf_em, hf_mp} == cr0_q[B_TS:B_MP])); // R8
endmodule

// File: rtl/pg_cr34_regs.sv
module pg_cr34_regs
  import pgctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr3,
  input  logic            wr4,
  input  logic            paging_on,
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] cr3_q,
  output logic [XLEN-1:0] cr4_q,
  output logic            cr3_evt,
  output logic            cr4_full_evt
);
  assign cr3_evt      = wr3 && paging_on;
  assign cr4_full_evt = wr4 && cr4_needs_flush(cr4_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr3_q <= '0;
      cr4_q <= '0;
    end else begin
      if (wr3) cr3_q <= data;
      if (wr4) cr4_q <= data;
    end
  end

  AST_CR3_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    wr3 |=> cr3_q == $past(data)); // R4
  AST_CR4_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr4 |=> cr4_q == $past(data)); // R5
endmodule

// File: rtl/pg_gate20.sv
module pg_gate20
  import pgctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gate_en,
  output logic [XLEN-1:0] addr_mask,
  output logic            gate_evt
);
  logic gate_q;

  assign gate_evt = gate_en ^ gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b1;
    else if (gate_evt) gate_q <= gate_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) addr_mask <= gate_mask(1'b1);
    else if (gate_evt) addr_mask <= gate_mask(gate_en);
  end

  AST_MASK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gate_evt) |-> addr_mask[B_GATE] == $past(gate_en)); // R6
endmodule

// File: rtl/pg_flush_arb.sv
module pg_flush_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic cr0_full_evt,
  input  logic cr3_evt,
  input  logic cr4_full_evt,
  input  logic gate_evt,
  output logic flush_req,
  output logic flush_all,
  output logic exit_req
);
  logic any_full;
  assign any_full = cr0_full_evt | cr4_full_evt | gate_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_req <= 1'b0;
      flush_all <= 1'b0;
      exit_req  <= 1'b0;
    end else begin
      flush_req <= any_full | cr3_evt;
      flush_all <= any_full;
      exit_req  <= gate_evt;
    end
  end

  AST_FULL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cr3_evt) && $past(gate_evt)) |-> (flush_req && flush_all)); // R9
endmodule

// File: rtl/paging_ctl_unit.sv
module paging_ctl_unit
  import pgctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        gate_en,
  output logic [31:0] cr0_q,
  output logic [31:0] cr3_q,
  output logic [31:0] cr4_q,
  output logic [31:0] addr_mask,
  output logic        flush_req,
  output logic        flush_all,
  output logic        exit_req,
  output logic        hf_pe,
  output logic        hf_addseg,
  output logic        hf_mp,
  output logic        hf_em,
  output logic        hf_ts
);
  logic wr0, wr3, wr4;
  logic cr0_full_evt, cr3_evt, cr4_full_evt, gate_evt;

  assign wr0 = wr_en && (wr_sel == SEL_CR0);
  assign wr3 = wr_en && (wr_sel == SEL_CR3);
  assign wr4 = wr_en && (wr_sel == SEL_CR4);

  pg_cr0_reg u_cr0 (
    .clk(clk), .rst_n(rst_n), .wr(wr0), .data(wr_data), .cr0_q(cr0_q),
    .full_evt(cr0_full_evt), .hf_pe(hf_pe), .hf_addseg(hf_addseg),
    .hf_mp(hf_mp), .hf_em(hf_em), .hf_ts(hf_ts)
  );

  pg_cr34_regs u_cr34 (
    .clk(clk), .rst_n(rst_n), .wr3(wr3), .wr4(wr4), .paging_on(cr0_q[B_PG]),
    .data(wr_data), .cr3_q(cr3_q), .cr4_q(cr4_q),
    .cr3_evt(cr3_evt), .cr4_full_evt(cr4_full_evt)
  );

  pg_gate20 u_gate (
    .clk(clk), .rst_n(rst_n), .gate_en(gate_en),
    .addr_mask(addr_mask), .gate_evt(gate_evt)
  );

  pg_flush_arb u_arb (
    .clk(clk), .rst_n(rst_n), .cr0_full_evt(cr0_full_evt), .cr3_evt(cr3_evt),
    .cr4_full_evt(cr4_full_evt), .gate_evt(gate_evt),
    .flush_req(flush_req), .flush_all(flush_all), .exit_req(exit_req)
  );

  AST_EXIT_IS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> (flush_req && flush_all)); // R7
  AST_MASK_CHANGE_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mask != $past(addr_mask)) |-> exit_req); // R7
  AST_CR0_PAGING_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (cr0_q[B_PG] != $past(cr0_q[B_PG])) |-> (flush_req && flush_all)); // R3
  AST_NO_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $past(gate_en) == addr_mask[B_GATE] && $stable(addr_mask)) |-> !flush_req); // R9
  AST_CR3_NONGLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr3) && $past(cr0_q[B_PG]) && $stable(addr_mask)) |-> (flush_req && !flush_all)); // R4
  AST_SEL3_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(wr_sel) == 2'd3) |-> ($stable(cr0_q) && $stable(cr3_q) && $stable(cr4_q))); // R10
endmodule

// File: tb/paging_ctl_unit_tb_top.sv
module paging_ctl_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic gate_en = 1'b1;
  logic [31:0] cr0_q, cr3_q, cr4_q, addr_mask;
  logic flush_req, flush_all, exit_req;
  logic hf_pe, hf_addseg, hf_mp, hf_em, hf_ts;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [31:0] m_cr0 = 32'h6000_0010;
  logic [31:0] m_cr3 = '0;
  logic [31:0] m_cr4 = '0;
  logic m_gate = 1'b1;

  always #5 clk = ~clk;

  paging_ctl_unit dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .gate_en(gate_en), .cr0_q(cr0_q), .cr3_q(cr3_q), .cr4_q(cr4_q),
    .addr_mask(addr_mask), .flush_req(flush_req), .flush_all(flush_all),
    .exit_req(exit_req), .hf_pe(hf_pe), .hf_addseg(hf_addseg), .hf_mp(hf_mp),
    .hf_em(hf_em), .hf_ts(hf_ts)
  );

  function automatic logic [31:0] exp_mask(input logic g);
    return g ? 32'hFFFF_FFFF : 32'hFFEF_FFFF;
  endfunction

  function automatic logic paging_bits_differ(input logic [31:0] a, input logic [31:0] b);
    return ((a ^ b) & 32'h8001_0001) != 0;
  endfunction

  function automatic logic cr4_bits_differ(input logic [31:0] a, input logic [31:0] b);
    return ((a ^ b) & 32'h0000_00B0) != 0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_state();
    chk("R2 cr0", cr0_q, m_cr0);
    chk("R4 cr3", cr3_q, m_cr3);
    chk("R5 cr4", cr4_q, m_cr4);
    chk("R6 mask", addr_mask, exp_mask(m_gate));
    chk("R8 flags", {27'd0, hf_pe, hf_addseg, hf_mp, hf_em, hf_ts},
        {27'd0, m_cr0[0], ~m_cr0[0], m_cr0[1], m_cr0[2], m_cr0[3]});
  endtask

  // one operation: drive, let one edge act, check, then one idle edge
  task automatic do_op(input logic en, input logic [1:0] sel,
                       input logic [31:0] d, input logic g);
    logic full, req, ex;
    full = 1'b0; req = 1'b0; ex = 1'b0;
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d; gate_en = g;
    if (g != m_gate) begin full = 1'b1; req = 1'b1; ex = 1'b1; m_gate = g; end
    if (en) begin
      case (sel)
        2'd0: begin
          if (paging_bits_differ(m_cr0, d)) begin full = 1'b1; req = 1'b1; end
          m_cr0 = d | 32'h0000_0010;
        end
        2'd1: begin
          if (m_cr0[31]) req = 1'b1;
          m_cr3 = d;
        end
        2'd2: begin
          if (cr4_bits_differ(m_cr4, d)) begin full = 1'b1; req = 1'b1; end
          m_cr4 = d;
        end
        default: ; // R10: no effect
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    chk_state();
    chk("R3/R4/R5/R7 flush_req", {31'd0, flush_req}, {31'd0, req});
    if (req) chk("R4/R9 flush_all", {31'd0, flush_all}, {31'd0, full});
    chk("R7 exit_req", {31'd0, exit_req}, {31'd0, ex});
    @(negedge clk);
    chk("R9 pulse flush", {31'd0, flush_req}, 32'd0);
    chk("R9 pulse exit", {31'd0, exit_req}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0017);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cr0", cr0_q, 32'h6000_0010);
    chk("R1 cr3", cr3_q, 32'd0);
    chk("R1 cr4", cr4_q, 32'd0);
    chk("R1 mask", addr_mask, 32'hFFFF_FFFF);
    chk("R1 flush", {30'd0, flush_req, exit_req}, 32'd0);

    // R2: clearing bit 4 still reads 1; paging bits unchanged -> no flush (R3)
    do_op(1'b1, 2'd0, 32'h0000_000E, 1'b1);
    // R4: CR3 write with paging off -> stored, no flush
    do_op(1'b1, 2'd1, 32'h1234_5000, 1'b1);
    // R3: set PG and PE -> full flush
    do_op(1'b1, 2'd0, 32'h8000_0001, 1'b1);
    // R3: same paging bits, other bits differ -> no flush
    do_op(1'b1, 2'd0, 32'h8000_000F, 1'b1);
    // R4: CR3 write with paging on -> non-global flush
    do_op(1'b1, 2'd1, 32'hABCD_E000, 1'b1);
    // R5: CR4 non-relevant bit -> no flush; then PAE -> flush
    do_op(1'b1, 2'd2, 32'h0000_0008, 1'b1);
    do_op(1'b1, 2'd2, 32'h0000_0028, 1'b1);
    // R7: gate off -> flush + exit; same level again -> nothing
    do_op(1'b0, 2'd0, 32'd0, 1'b0);
    do_op(1'b0, 2'd0, 32'd0, 1'b0);
    // R9: gate change with CR3 write (paging on) -> single full flush
    do_op(1'b1, 2'd1, 32'h0055_5000, 1'b1);
    // R10: select 3 has no effect
    do_op(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b1);
    // R3: clear WP only
    do_op(1'b1, 2'd0, 32'h8001_0001, 1'b1);
    do_op(1'b1, 2'd0, 32'h8000_0001, 1'b1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [1:0] s;
      logic g;
      d = $urandom();
      s = 2'($urandom_range(0, 3));
      g = ($urandom_range(0, 7) == 0) ? ~m_gate : m_gate;
      do_op($urandom_range(0, 3) != 0, s, d, g);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule